// File: doc/BRIEF.md
# Monitor Statistics and Energy Accumulator

This block sits behind the sample filter of a current or power monitor and turns a stream of signed current and voltage samples, each qualified by a valid strobe, into summary values. It produces two averages of the current: a sliding one over a selectable power-of-two window, and a block one over a fixed number of samples. It also tracks the largest current magnitude and the signed minimum and maximum current. A signed energy sum adds either the voltage-current product or a scaled square of the current times a resistance code.

The extrema either hold the worst value until the host strobes a read, or restart on their own at every block. The energy sum either wraps, saturates, or wraps while setting a sticky roll-over flag. A freeze input from the power-down controller stops every accumulator so that the held values can be snapshotted. The block serves one channel. Its host side consists of a read strobe for the extrema and a clear strobe for the roll-over flag.

Top module: `mstat_top`

## Requirements
- R1: After reset `mov_avg`, `blk_avg`, `energy` and `pk_abs` are 0, `blk_vld` and `roll_flag` are 0, `min_cur` is +32767 and `max_cur` is -32768, so the first accepted sample loads both.
- R2: A sample is accepted on a clock edge where `smp_vld` is 1 and `freeze` is 0. One cycle after such an edge, `mov_avg` equals the floor of (sum of the last 2^k accepted samples) / 2^k. Here k is `cfg_win`, clamped to 6, and history slots not yet filled count as zero.
- R3: A change of the clamped window value clears the moving history on the edge where it is seen, and that edge's accepted sample becomes the only history entry.
- R4: On every 8th accepted sample `blk_avg` becomes the floor of the sum of those 8 samples / 8, and `blk_vld` is 1 for exactly the following cycle.
- R5: With `cfg_hold`=1, `pk_abs`, `min_cur` and `max_cur` keep the extremes of all accepted samples since they were last armed. A `rd_stats` strobe re-arms them: to the current sample if one is accepted on that edge, otherwise to the reset codes.
- R6: With `cfg_hold`=0, `rd_stats` has no effect, and the first accepted sample of each 8-sample block reloads all three extrema.
- R7: Each accepted sample adds a term to `energy`. The term is `smp_cur`·`smp_volt` when `cfg_sqr`=0, and ((`smp_cur`²) >> 16)·`cfg_res` when `cfg_sqr`=1.
- R8: With `cfg_ovf`=0, an energy sum outside the 32-bit signed range wraps in two's complement and `roll_flag` is not set.
- R9: With `cfg_ovf`=1, an out-of-range energy sum clamps to +2^31-1 or -2^31.
- R10: With `cfg_ovf`=2 or 3, an out-of-range energy sum wraps and sets the sticky `roll_flag`. `clr_roll` clears the flag, but an overflow on the same edge keeps it set.
- R11: While `freeze` is 1, samples are ignored: energy, the moving and block sums and the extrema keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_cur | input | 16 | Signed current sample |
| smp_volt | input | 16 | Signed voltage sample |
| freeze | input | 1 | Power-down hold of all accumulators |
| cfg_win | input | 3 | Moving window exponent, clamped to 6 |
| cfg_hold | input | 1 | 1: extrema held until read; 0: restart per block |
| cfg_ovf | input | 2 | Energy overflow policy: 0 wrap, 1 saturate, 2/3 wrap with flag |
| cfg_sqr | input | 1 | 1: accumulate squared current times resistance |
| cfg_res | input | 16 | Unsigned resistance code |
| rd_stats | input | 1 | Host read strobe for the extrema |
| clr_roll | input | 1 | Clears the roll-over flag |
| mov_avg | output | 16 | Signed moving average |
| blk_avg | output | 16 | Signed block average |
| blk_vld | output | 1 | One-cycle pulse with a new block average |
| pk_abs | output | 16 | Unsigned largest current magnitude |
| min_cur | output | 16 | Signed minimum current |
| max_cur | output | 16 | Signed maximum current |
| energy | output | 32 | Signed energy sum |
| roll_flag | output | 1 | Sticky energy roll-over flag |

## Verification
A stale or wrongly indexed history slot shows up in `mov_avg` as soon as the window fills: with window 8, that is the ninth accepted sample, and every later sample carries the error. A miscount in the block counter moves the `blk_vld` pulse and also shifts the cycle on which the extrema restart in continuous mode, so both outputs disagree within one block. An error in the overflow decision shows in `energy` on the edge right after the first out-of-range sum. It takes the form of a sign flip where a clamp was expected, or a roll-over flag that is missing or spurious. That is why the overflow policies are driven with full-scale products, which cross the 32-bit limit within three samples.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  typedef enum logic [1:0] {
    OVF_WRAP      = 2'd0,
    OVF_SAT       = 2'd1,
    OVF_WRAP_FLAG = 2'd2,
    OVF_WRAP_ALT  = 2'd3
  } ovf_mode_e;

  // True when the policy raises the sticky roll-over flag.
  function automatic logic flags_roll(input ovf_mode_e m);
    return (m == OVF_WRAP_FLAG) || (m == OVF_WRAP_ALT);
  endfunction
endpackage

// File: rtl/mstat_movavg.sv
module mstat_movavg #(
  parameter int DW     = 16,
  parameter int MAXLOG = 6,
  parameter int WW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [DW-1:0] smp,
  input  logic [WW-1:0]        win,
  output logic signed [DW-1:0] avg
);
  localparam int HW = 1 << MAXLOG;
  localparam int SW = DW + MAXLOG;

  logic signed [DW-1:0] hist [HW];
  logic signed [SW-1:0] sum;
  logic [WW-1:0]        win_q;
  logic [WW-1:0]        win_eff;
  logic                 win_chg;
  logic [MAXLOG-1:0]    tail_idx;
  logic signed [DW-1:0] leaving;

  always_comb begin
    win_eff  = (win > WW'(MAXLOG)) ? WW'(MAXLOG) : win;
    win_chg  = (win_eff != win_q);
    tail_idx = MAXLOG'((32'd1 << win_q) - 32'd1);
    leaving  = hist[tail_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < HW; j++) hist[j] <= '0;
      sum   <= '0;
      win_q <= '0;
    end else if (win_chg) begin
      for (int j = 1; j < HW; j++) hist[j] <= '0;
      hist[0] <= upd ? smp : '0;
      sum     <= upd ? SW'(smp) : '0;
      win_q   <= win_eff;
    end else if (upd) begin
      for (int j = 1; j < HW; j++) hist[j] <= hist[j-1];
      hist[0] <= smp;
      sum     <= sum + SW'(smp) - SW'(leaving);
    end
  end

  assign avg = DW'(sum >>> win_q);

  // R3: a flush without a sample leaves an empty history
  p_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_chg && !upd) |=> (avg == '0));
  // R2: a window of one follows the last accepted sample
  p_win1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == '0 && !win_chg && upd) |=> (avg == $past(smp)));
endmodule

// File: rtl/mstat_blkavg.sv
module mstat_blkavg #(
  parameter int DW   = 16,
  parameter int BLOG = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [DW-1:0] smp,
  output logic                 first,
  output logic signed [DW-1:0] avg,
  output logic                 vld
);
  localparam int SW = DW + BLOG;

  logic [BLOG-1:0]      cnt;
  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] acc_nxt;
  logic                 last;

  always_comb begin
    acc_nxt = acc + SW'(smp);
    last    = (cnt == {BLOG{1'b1}});
    first   = (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
      avg <= '0;
      vld <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (upd) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          avg <= DW'(acc_nxt >>> BLOG);
          vld <= 1'b1;
          acc <= '0;
        end else begin
          acc <= acc_nxt;
        end
      end
    end
  end

  // R4: the result strobe lasts one cycle
  p_blk_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);
  // R4: a result follows an accepted sample
  p_blk_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(upd));
endmodule

// File: rtl/mstat_extrema.sv
module mstat_extrema #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [DW-1:0] smp,
  input  logic                 hold,
  input  logic                 rd,
  input  logic                 first,
  output logic [DW-1:0]        pk,
  output logic signed [DW-1:0] mn,
  output logic signed [DW-1:0] mx
);
  localparam logic signed [DW-1:0] TOP = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] BOT = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] mag(input logic signed [DW-1:0] s);
    return s[DW-1] ? DW'(-s) : DW'(s);
  endfunction

  logic          rearm;
  logic [DW-1:0] smp_mag;

  always_comb begin
    rearm   = hold ? rd : (upd && first);
    smp_mag = mag(smp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk <= '0;
      mn <= TOP;
      mx <= BOT;
    end else if (rearm) begin
      pk <= upd ? smp_mag : '0;
      mn <= upd ? smp : TOP;
      mx <= upd ? smp : BOT;
    end else if (upd) begin
      if (smp_mag > pk) pk <= smp_mag;
      if (smp < mn)     mn <= smp;
      if (smp > mx)     mx <= smp;
    end
  end

  // R5: after any accepted sample the range is ordered
  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (mx >= mn));
  // R5: a read without a sample returns the block to reset codes
  p_rdclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && rd && !upd) |=> (pk == '0 && mn == TOP && mx == BOT));
  // R6: in continuous mode a read alone changes nothing
  p_rdign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && rd && !upd) |=> ($stable(pk) && $stable(mn) && $stable(mx)));
endmodule

// File: rtl/mstat_energy.sv
module mstat_energy
  import mstat_pkg::*;
#(
  parameter int DW = 16,
  parameter int EW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [DW-1:0] cur,
  input  logic signed [DW-1:0] volt,
  input  logic                 sqr,
  input  logic [DW-1:0]        res,
  input  logic [1:0]           mode,
  input  logic                 clr,
  output logic signed [EW-1:0] energy,
  output logic                 roll
);
  localparam int TW = 2 * DW + 1;
  localparam int SW = ((EW > TW) ? EW : TW) + 1;
  localparam logic signed [SW-1:0] EMAX = {{(SW-EW+1){1'b0}}, {(EW-1){1'b1}}};
  localparam logic signed [SW-1:0] EMIN = ~EMAX;

  function automatic logic signed [TW-1:0] calc_term(
    input logic signed [DW-1:0] c,
    input logic signed [DW-1:0] v,
    input logic                 sq,
    input logic [DW-1:0]        r
  );
    logic signed [2*DW-1:0] pv;
    logic signed [2*DW-1:0] ii;
    logic [2*DW-1:0]        sp;
    pv = c * v;
    ii = c * c;
    sp = {{DW{1'b0}}, ii[2*DW-1:DW]} * {{DW{1'b0}}, r};
    return sq ? $signed({1'b0, sp}) : $signed({pv[2*DW-1], pv});
  endfunction

  ovf_mode_e            pol;
  logic signed [TW-1:0] term;
  logic signed [SW-1:0] nxt;
  logic                 ovf;
  logic signed [EW-1:0] clamped;

  always_comb begin
    pol     = ovf_mode_e'(mode);
    term    = calc_term(cur, volt, sqr, res);
    nxt     = {{(SW-EW){energy[EW-1]}}, energy} + {{(SW-TW){term[TW-1]}}, term};
    ovf     = (nxt > EMAX) || (nxt < EMIN);
    clamped = nxt[SW-1] ? EW'(EMIN) : EW'(EMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      energy <= '0;
      roll   <= 1'b0;
    end else begin
      if (upd) energy <= (ovf && pol == OVF_SAT) ? clamped : EW'(nxt);
      if (upd && ovf && flags_roll(pol)) roll <= 1'b1;
      else if (clr)                      roll <= 1'b0;
    end
  end

  // R9: a saturated sum stays at full scale under non-negative terms
  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && pol == OVF_SAT && energy == EW'(EMAX) && term >= 0)
      |=> (energy == EW'(EMAX)));
  // R10: only a flagging policy can raise the roll-over flag
  p_roll_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(roll) |-> $past(mode[1]));
  // R8: wrap mode never raises the flag
  p_wrap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == OVF_WRAP && !roll) |=> !roll);
endmodule

// File: rtl/mstat_top.sv
module mstat_top #(
  parameter  int DW           = 16,
  parameter  int EW           = 32,
  parameter  int MAX_WIN_LOG2 = 6,
  parameter  int BLK_LOG2     = 3,
  localparam int WIN_W        = $clog2(MAX_WIN_LOG2 + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_cur,
  input  logic signed [DW-1:0] smp_volt,
  input  logic                 freeze,
  input  logic [WIN_W-1:0]     cfg_win,
  input  logic                 cfg_hold,
  input  logic [1:0]           cfg_ovf,
  input  logic                 cfg_sqr,
  input  logic [DW-1:0]        cfg_res,
  input  logic                 rd_stats,
  input  logic                 clr_roll,
  output logic signed [DW-1:0] mov_avg,
  output logic signed [DW-1:0] blk_avg,
  output logic                 blk_vld,
  output logic [DW-1:0]        pk_abs,
  output logic signed [DW-1:0] min_cur,
  output logic signed [DW-1:0] max_cur,
  output logic signed [EW-1:0] energy,
  output logic                 roll_flag
);
  logic upd;
  logic blk_first;

  assign upd = smp_vld && !freeze;

  mstat_movavg #(.DW(DW), .MAXLOG(MAX_WIN_LOG2), .WW(WIN_W)) i_mov (
    .clk(clk), .rst_n(rst_n), .upd(upd), .smp(smp_cur), .win(cfg_win), .avg(mov_avg)
  );

  mstat_blkavg #(.DW(DW), .BLOG(BLK_LOG2)) i_blk (
    .clk(clk), .rst_n(rst_n), .upd(upd), .smp(smp_cur),
    .first(blk_first), .avg(blk_avg), .vld(blk_vld)
  );

  mstat_extrema #(.DW(DW)) i_ext (
    .clk(clk), .rst_n(rst_n), .upd(upd), .smp(smp_cur), .hold(cfg_hold),
    .rd(rd_stats), .first(blk_first), .pk(pk_abs), .mn(min_cur), .mx(max_cur)
  );

  mstat_energy #(.DW(DW), .EW(EW)) i_nrg (
    .clk(clk), .rst_n(rst_n), .upd(upd), .cur(smp_cur), .volt(smp_volt),
    .sqr(cfg_sqr), .res(cfg_res), .mode(cfg_ovf), .clr(clr_roll),
    .energy(energy), .roll(roll_flag)
  );

  // R11: frozen edges leave the energy sum untouched
  p_freeze_nrg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(energy));
  // R11: frozen edges never complete a block
  p_freeze_blk_r11: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !blk_vld);
endmodule

// File: tb/test_mstat_top.sv
`timescale 1ns/1ps
module test_mstat_top;
  localparam int BLOG = 3;
  localparam int BLK  = 1 << BLOG;
  localparam int NV   = 20;
  // stimulus rows: {current, voltage}
  localparam logic [31:0] VEC [NV] = '{
    {16'(100), 16'(200)},   {16'(-50), 16'(300)},   {16'(1000), 16'(10)},
    {16'(-2000), 16'(5)},   {16'(30), 16'(30)},     {16'(0), 16'(0)},
    {16'(32767), 16'(1)},   {16'(-32768), 16'(1)},  {16'(5), 16'(-5)},
    {16'(7), 16'(7)},       {16'(-1), 16'(1)},      {16'(400), 16'(-2)},
    {16'(12), 16'(12)},     {16'(-300), 16'(3)},    {16'(250), 16'(4)},
    {16'(60), 16'(6)},      {16'(-7), 16'(9)},      {16'(8), 16'(8)},
    {16'(900), 16'(-1)},    {16'(-900), 16'(-1)}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [15:0] smp_cur = '0, smp_volt = '0;
  logic freeze = 1'b0;
  logic [2:0] cfg_win = 3'd3;
  logic cfg_hold = 1'b1;
  logic [1:0] cfg_ovf = 2'd0;
  logic cfg_sqr = 1'b0;
  logic [15:0] cfg_res = '0;
  logic rd_stats = 1'b0, clr_roll = 1'b0;
  logic signed [15:0] mov_avg, blk_avg, min_cur, max_cur;
  logic [15:0] pk_abs;
  logic blk_vld, roll_flag;
  logic signed [31:0] energy;

  always #2.5 clk = ~clk;

  mstat_top i_mstat_top (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_cur(smp_cur), .smp_volt(smp_volt),
    .freeze(freeze), .cfg_win(cfg_win), .cfg_hold(cfg_hold), .cfg_ovf(cfg_ovf),
    .cfg_sqr(cfg_sqr), .cfg_res(cfg_res), .rd_stats(rd_stats), .clr_roll(clr_roll),
    .mov_avg(mov_avg), .blk_avg(blk_avg), .blk_vld(blk_vld), .pk_abs(pk_abs),
    .min_cur(min_cur), .max_cur(max_cur), .energy(energy), .roll_flag(roll_flag)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state
  int mhist [64];
  int mwin = 0, mcnt = 0, macc = 0;
  int e_mov = 0, e_blk = 0, e_bv = 0, e_pk = 0, e_mn = 32767, e_mx = -32768, e_fl = 0;
  longint e_en = 0;
  string t_mov = "R2", t_blk = "R4", t_ext = "R5", t_en = "R7";

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(input bit v, input int c, input int vo, input bit rd, input bit clr);
    bit up = v && !freeze;
    int we = (cfg_win > 6) ? 6 : int'(cfg_win);
    int s = 0;
    longint t, n;
    bit ov;
    // moving average
    if (we != mwin) begin
      foreach (mhist[j]) mhist[j] = 0;
      if (up) mhist[0] = c;
      mwin = we;
    end else if (up) begin
      for (int j = 63; j > 0; j--) mhist[j] = mhist[j-1];
      mhist[0] = c;
    end
    for (int j = 0; j < (1 << mwin); j++) s += mhist[j];
    e_mov = s >>> mwin;
    // extrema (uses block position before this sample)
    if ((cfg_hold && rd) || (!cfg_hold && up && mcnt == 0)) begin
      if (up) begin e_pk = (c < 0) ? -c : c; e_mn = c; e_mx = c; end
      else begin e_pk = 0; e_mn = 32767; e_mx = -32768; end
    end else if (up) begin
      if (((c < 0) ? -c : c) > e_pk) e_pk = (c < 0) ? -c : c;
      if (c < e_mn) e_mn = c;
      if (c > e_mx) e_mx = c;
    end
    // block average
    e_bv = 0;
    if (up) begin
      if (mcnt == BLK - 1) begin
        e_blk = (macc + c) >>> BLOG; e_bv = 1; macc = 0; mcnt = 0;
      end else begin
        macc += c; mcnt++;
      end
    end
    // energy
    if (up) begin
      t = cfg_sqr ? (((longint'(c) * c) >> 16) * longint'(cfg_res)) : longint'(c) * vo;
      n = e_en + t;
      ov = (n > 64'sd2147483647) || (n < -64'sd2147483648);
      if (ov && cfg_ovf == 2'd1) n = (n > 0) ? 64'sd2147483647 : -64'sd2147483648;
      else if (ov) n = longint'(int'(n));
      e_en = n;
      if (ov && cfg_ovf[1]) e_fl = 1;
      else if (clr) e_fl = 0;
    end else if (clr) e_fl = 0;
  endtask

  task automatic compare();
    chk(t_mov, "mov_avg", mov_avg, e_mov);
    chk(t_blk, "blk_vld", blk_vld, e_bv);
    chk(t_blk, "blk_avg", blk_avg, e_blk);
    chk(t_ext, "pk_abs", pk_abs, e_pk);
    chk(t_ext, "min_cur", min_cur, e_mn);
    chk(t_ext, "max_cur", max_cur, e_mx);
    chk(t_en, "energy", energy, e_en);
    chk(t_en, "roll_flag", roll_flag, e_fl);
  endtask

  // one clock: drive away from the edge, evaluate, sample 1 ns after the edge
  task automatic step(input bit v, input int c, input int vo, input bit rd, input bit clr);
    smp_vld = v; smp_cur = 16'(c); smp_volt = 16'(vo); rd_stats = rd; clr_roll = clr;
    model(v, c, vo, rd, clr);
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    foreach (mhist[j]) mhist[j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    chk("R1", "mov_avg", mov_avg, 0);
    chk("R1", "blk_avg", blk_avg, 0);
    chk("R1", "blk_vld", blk_vld, 0);
    chk("R1", "pk_abs", pk_abs, 0);
    chk("R1", "min_cur", min_cur, 32767);
    chk("R1", "max_cur", max_cur, -32768);
    chk("R1", "energy", energy, 0);
    chk("R1", "roll_flag", roll_flag, 0);

    // R2 R4 R5 R7: table walk, window 8, latched extrema, some gaps
    for (int k = 0; k < NV; k++) begin
      step(k % 5 != 4, int'($signed(VEC[k][31:16])), int'($signed(VEC[k][15:0])), 1'b0, 1'b0);
    end
    for (int k = 0; k < NV; k++) begin
      step(1'b1, int'($signed(VEC[NV-1-k][31:16])), int'($signed(VEC[NV-1-k][15:0])), 1'b0, 1'b0);
    end

    // R3: window change flushes history
    t_mov = "R3";
    cfg_win = 3'd1;
    step(1'b0, 0, 0, 1'b0, 1'b0);
    step(1'b1, 81, 1, 1'b0, 1'b0);
    step(1'b1, -20, 1, 1'b0, 1'b0);
    cfg_win = 3'd7;   // clamps to 6
    step(1'b1, 640, 1, 1'b0, 1'b0);
    for (int k = 0; k < 70; k++) step(1'b1, k * 37 - 900, 1, 1'b0, 1'b0);
    t_mov = "R2";
    cfg_win = 3'd0;
    step(1'b1, -123, 2, 1'b0, 1'b0);
    step(1'b1, 77, 2, 1'b0, 1'b0);
    cfg_win = 3'd2;

    // R5: read re-arms to the current sample, or to reset codes
    step(1'b1, -4000, 1, 1'b1, 1'b0);
    step(1'b1, 300, 1, 1'b0, 1'b0);
    step(1'b0, 0, 0, 1'b1, 1'b0);
    step(1'b1, 9, 1, 1'b0, 1'b0);

    // R6: continuous mode, block restart, read ignored
    t_ext = "R6";
    cfg_hold = 1'b0;
    for (int k = 0; k < 20; k++) step(k != 6, (k % 3 == 0) ? -k * 100 : k * 55, 1, k % 4 == 1, 1'b0);
    step(1'b0, 0, 0, 1'b1, 1'b0);

    // R11: freeze holds everything
    t_mov = "R11"; t_blk = "R11"; t_ext = "R11"; t_en = "R11";
    freeze = 1'b1;
    for (int k = 0; k < 9; k++) step(1'b1, 20000 - k, 3, 1'b0, 1'b0);
    freeze = 1'b0;
    t_mov = "R2"; t_blk = "R4"; t_ext = "R6"; t_en = "R7";

    // R9: saturation at both ends
    t_en = "R9";
    cfg_ovf = 2'd1;
    for (int k = 0; k < 4; k++) step(1'b1, 32767, 32767, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) step(1'b1, -32768, 32767, 1'b0, 1'b0);

    // R8: wrap without flag
    t_en = "R8";
    cfg_ovf = 2'd0;
    for (int k = 0; k < 3; k++) step(1'b1, -32768, 32767, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b1, 32767, 32767, 1'b0, 1'b0);

    // R10: flagged wrap, clear, and set winning over clear
    t_en = "R10";
    cfg_ovf = 2'd2;
    for (int k = 0; k < 4; k++) step(1'b1, 32767, 32767, 1'b0, 1'b0);
    step(1'b1, 3, 3, 1'b0, 1'b1);
    step(1'b0, 0, 0, 1'b0, 1'b0);
    cfg_ovf = 2'd3;
    for (int k = 0; k < 3; k++) step(1'b1, 32767, 32767, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) step(1'b1, 32767, 32767, 1'b0, 1'b1);

    // R7: squared-current mode
    t_en = "R7";
    cfg_ovf = 2'd0; cfg_sqr = 1'b1; cfg_res = 16'd1000;
    step(1'b1, 20000, 0, 1'b0, 1'b0);
    step(1'b1, -32768, 5, 1'b0, 1'b0);
    cfg_res = 16'd65535;
    step(1'b1, 12345, -9, 1'b0, 1'b0);
    step(1'b1, 255, 0, 1'b0, 1'b0);

    finish_run();
  end
endmodule